// File: doc/BRIEF.md
# Performance-Monitor Event-ID Read Access Arbiter

This block decides what happens when software reads the system register that reports which common performance-monitor events in the upper event window are present. Each request carries the current exception level and the decoded system-register encoding. A set of configuration levels comes with it: feature-present flags, user-access enables, monitor-level and hypervisor-level trap bits, fine-grained read-trap controls, and the host routing state. The block resolves a fixed, level-dependent priority chain. It returns exactly one outcome: the read data, UNDEFINED, a trap to EL1, EL2 or EL3 with its syndrome class, or "not claimed" when the encoding belongs to some other register.

The 64-bit event-presence bitmap is a build-time parameter. The block drives it out as the read data, and the upper half is masked unless the high-window feature is present. Requests and responses use a valid/ready handshake. Each accepted request produces one registered response in the following cycle, and that response is held until the consumer takes it.

Top module: `pmu_evid_rd_arb`

## Requirements
- R1: The block claims only encoding op0=3, op1=3, CRn=9, CRm=12, op2=7. Any other encoding gives outcome code 5 (not claimed), whatever the configuration.
- R2: A claimed access with `has_pmu` low gives UNDEFINED (code 1) at every level.
- R3: At EL0, EL1 and EL2, when EL3 exists, `sdd_undef_prio` is high and `mon_pm_trap` is high, the result is UNDEFINED, and this check comes before every other trap.
- R4: At EL0, when `usr_access_en` is low and the user extension is absent or `usr_ext_en` is low, the access traps. It goes to EL2 (code 3) when `el2_enabled` and `el2_route_gen` are both high, and to EL1 (code 2) otherwise.
- R5: At EL0, when the user extension is present and `usr_id_trap` is high, the access traps with the same EL2/EL1 routing as R4. The R4 rule is checked first.
- R6: At EL0 and EL1, a fine-grained trap to EL2 is taken when all of the following hold: EL2 is enabled, the fine-trap feature is present, EL3 is absent or `el3_fine_en` is high, and `fine_rd_trap` is high. At EL0 the access must also not be in host context (`el0_host` low); this term does not apply at EL1. The check comes after R3 to R5.
- R7: At EL0 and EL1, after the fine-grained check, `hyp_pm_trap` with EL2 enabled traps to EL2.
- R8: The last check is this: when EL3 exists and `mon_pm_trap` is high, the result is UNDEFINED if `sdd_undef` is high, and a trap to EL3 (code 4) otherwise. EL2 applies only R3 and this rule. EL3 always reads (code 0).
- R9: `rsp_ec` is 0x18 for every trap outcome (codes 2 to 4) and zero for all other outcomes.
- R10: On a read, `rsp_data[31:0]` is the low half of the bitmap. `rsp_data[63:32]` is the high half when `has_hi_events` is set and zero otherwise. For any other outcome `rsp_data` is zero.
- R11: `req_ready` equals `!rsp_valid || rsp_ready`. A request accepted at a clock edge is presented at the next edge. The response holds with the same values while `rsp_valid` is high and `rsp_ready` is low.
- R12: While `rst` is high, and after its synchronous release, `rsp_valid` is low and `req_ready` is high.
- R13: `rsp_kind` codes are 0 read, 1 UNDEFINED, 2 trap EL1, 3 trap EL2, 4 trap EL3 and 5 not claimed, with exactly one per response. `req_el` values 0 to 3 select EL0 to EL3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted |
| req_el | input | 2 | Exception level of the access |
| req_op0 | input | 2 | Encoding field op0 |
| req_op1 | input | 3 | Encoding field op1 |
| req_crn | input | 4 | Encoding field CRn |
| req_crm | input | 4 | Encoding field CRm |
| req_op2 | input | 3 | Encoding field op2 |
| has_pmu | input | 1 | Base performance-monitor feature present |
| has_hi_events | input | 1 | Upper event window feature present |
| has_user_ext | input | 1 | User-access extension present |
| has_fine_trap | input | 1 | Fine-grained trap feature present |
| has_el3 | input | 1 | EL3 implemented |
| el2_enabled | input | 1 | EL2 enabled in the current state |
| el0_host | input | 1 | EL0 runs in host context |
| el2_route_gen | input | 1 | Route EL0 exceptions to EL2 |
| usr_access_en | input | 1 | User access enable |
| usr_ext_en | input | 1 | Extended user access enable |
| usr_id_trap | input | 1 | Trap user ID-register reads |
| fine_rd_trap | input | 1 | Fine-grained read trap for this register |
| el3_fine_en | input | 1 | EL3 allows fine-grained traps |
| hyp_pm_trap | input | 1 | EL2 performance-monitor trap |
| mon_pm_trap | input | 1 | EL3 performance-monitor trap |
| sdd_undef_prio | input | 1 | Secure-debug UNDEFINED takes priority |
| sdd_undef | input | 1 | Secure-debug turns EL3 trap into UNDEFINED |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Response taken |
| rsp_kind | output | 3 | Outcome code |
| rsp_ec | output | 6 | Syndrome class |
| rsp_data | output | 64 | Read data |

## Verification
A behavioural model in the bench predicts every response. The stimulus draws trap bits sparsely so that each step of the chain is reached as the first one to fire. Encodings are mostly correct, with single-field corruptions mixed in, which separates "not claimed" from a claimed UNDEFINED. Host context is toggled at both EL0 and EL1, which shows whether the fine-grained host term is applied only at EL0. The same configuration with and without EL2 routing shows whether EL0 traps are sent to EL1 or EL2. Random stalls on `rsp_ready` check that responses hold while stalled and that `req_ready` follows R11.

// File: rtl/pmu_evid_pkg.sv
package pmu_evid_pkg;

    typedef enum logic [1:0] {
        LVL_0 = 2'd0,
        LVL_1 = 2'd1,
        LVL_2 = 2'd2,
        LVL_3 = 2'd3
    } xlevel_e;

    typedef enum logic [2:0] {
        OUT_READ    = 3'd0,
        OUT_UNDEF   = 3'd1,
        OUT_TRAP1   = 3'd2,
        OUT_TRAP2   = 3'd3,
        OUT_TRAP3   = 3'd4,
        OUT_NOCLAIM = 3'd5
    } outcome_e;

    localparam logic [5:0] TRAP_CLASS = 6'h18;

    typedef struct packed {
        logic [1:0] op0;
        logic [2:0] op1;
        logic [3:0] crn;
        logic [3:0] crm;
        logic [2:0] op2;
    } sysenc_t;

    localparam sysenc_t EVID_HI_ENC = '{op0: 2'b11, op1: 3'b011, crn: 4'b1001,
                                        crm: 4'b1100, op2: 3'b111};

    // Configuration seen by the priority chain
    typedef struct packed {
        logic has_pmu;
        logic has_uext;
        logic has_fgt;
        logic has_el3;
        logic el2_en;
        logic in_host;
        logic route_gen;
        logic usr_en;
        logic usr_ext_en;
        logic usr_id_trap;
        logic fgt_rd_trap;
        logic el3_fgt_en;
        logic hyp_pm_trap;
        logic mon_pm_trap;
        logic sdd_prio;
        logic sdd_undef;
    } trapcfg_t;

    function automatic outcome_e user_route(input trapcfg_t c);
        return (c.el2_en && c.route_gen) ? OUT_TRAP2 : OUT_TRAP1;
    endfunction

    function automatic logic is_trap(input outcome_e k);
        return (k == OUT_TRAP1) || (k == OUT_TRAP2) || (k == OUT_TRAP3);
    endfunction

endpackage

// File: rtl/pmu_enc_match.sv
module pmu_enc_match
    import pmu_evid_pkg::*;
#(
    parameter sysenc_t MATCH = EVID_HI_ENC
) (
    input  sysenc_t enc,
    output logic    hit
);
    localparam int NFIELD = 5;
    logic [NFIELD-1:0] fld_eq;

    assign fld_eq[0] = (enc.op0 == MATCH.op0);
    assign fld_eq[1] = (enc.op1 == MATCH.op1);
    assign fld_eq[2] = (enc.crn == MATCH.crn);
    assign fld_eq[3] = (enc.crm == MATCH.crm);
    assign fld_eq[4] = (enc.op2 == MATCH.op2);

    assign hit = &fld_eq;
endmodule

// File: rtl/pmu_trap_chain.sv
module pmu_trap_chain
    import pmu_evid_pkg::*;
(
    input  xlevel_e    lvl,
    input  logic       hit,
    input  trapcfg_t   cfg,
    output outcome_e   kind,
    output logic [5:0] ec
);
    logic     undef_first;
    logic     usr_block;
    logic     id_block;
    logic     fgt_hit;
    logic     hyp_hit;
    logic     low_lvl;
    outcome_e mon_tail;

    assign low_lvl     = (lvl == LVL_0) || (lvl == LVL_1);
    assign undef_first = cfg.has_el3 && cfg.sdd_prio && cfg.mon_pm_trap;
    assign usr_block   = !cfg.usr_en && (!cfg.has_uext || !cfg.usr_ext_en);
    assign id_block    = cfg.has_uext && cfg.usr_id_trap;
    assign fgt_hit     = low_lvl && cfg.el2_en && cfg.has_fgt && cfg.fgt_rd_trap
                         && (!cfg.has_el3 || cfg.el3_fgt_en)
                         && !((lvl == LVL_0) && cfg.in_host);
    assign hyp_hit     = low_lvl && cfg.el2_en && cfg.hyp_pm_trap;

    always_comb begin
        if (cfg.has_el3 && cfg.mon_pm_trap)
            mon_tail = cfg.sdd_undef ? OUT_UNDEF : OUT_TRAP3;
        else
            mon_tail = OUT_READ;
    end

    always_comb begin
        if (!hit)                              kind = OUT_NOCLAIM;
        else if (!cfg.has_pmu)                 kind = OUT_UNDEF;
        else if (lvl == LVL_3)                 kind = OUT_READ;
        else if (undef_first)                  kind = OUT_UNDEF;
        else if ((lvl == LVL_0) && usr_block)  kind = user_route(cfg);
        else if ((lvl == LVL_0) && id_block)   kind = user_route(cfg);
        else if (fgt_hit)                      kind = OUT_TRAP2;
        else if (hyp_hit)                      kind = OUT_TRAP2;
        else                                   kind = mon_tail;
    end

    assign ec = is_trap(kind) ? TRAP_CLASS : 6'd0;
endmodule

// File: rtl/pmu_rsp_stage.sv
module pmu_rsp_stage
    import pmu_evid_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  outcome_e          in_kind,
    input  logic [5:0]        in_ec,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_valid,
    input  logic              out_ready,
    output outcome_e          out_kind,
    output logic [5:0]        out_ec,
    output logic [DATA_W-1:0] out_data
);
    assign in_ready = !out_valid || out_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_kind  <= OUT_NOCLAIM;
            out_ec    <= '0;
            out_data  <= '0;
        end else if (in_ready) begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_kind <= in_kind;
                out_ec   <= in_ec;
                out_data <= in_data;
            end
        end
    end

    // R11: acceptance yields a response at the next edge
    a_r11_accept_next: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> out_valid);

    // R11: stalled response holds
    a_r11_hold: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_kind)
                                       && $stable(out_ec) && $stable(out_data)));

    // R9: syndrome class present exactly on traps
    a_r9_class: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (((out_ec == TRAP_CLASS) == is_trap(out_kind))
                       && ((out_ec == 6'd0) || (out_ec == TRAP_CLASS))));

    // R10: no data leaks on non-read outcomes
    a_r10_data_zero: assert property (@(posedge clk) disable iff (rst)
        (out_valid && (out_kind != OUT_READ)) |-> (out_data == '0));

    // R13: outcome code within the defined set
    a_r13_kind_legal: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_kind <= OUT_NOCLAIM));
endmodule

// File: rtl/pmu_evid_rd_arb.sv
module pmu_evid_rd_arb
    import pmu_evid_pkg::*;
#(
    parameter int              DATA_W  = 64,
    parameter logic [DATA_W-1:0] EVT_MAP = 64'h0001_00F3_7FF0_2A65
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_el,
    input  logic [1:0]        req_op0,
    input  logic [2:0]        req_op1,
    input  logic [3:0]        req_crn,
    input  logic [3:0]        req_crm,
    input  logic [2:0]        req_op2,
    input  logic              has_pmu,
    input  logic              has_hi_events,
    input  logic              has_user_ext,
    input  logic              has_fine_trap,
    input  logic              has_el3,
    input  logic              el2_enabled,
    input  logic              el0_host,
    input  logic              el2_route_gen,
    input  logic              usr_access_en,
    input  logic              usr_ext_en,
    input  logic              usr_id_trap,
    input  logic              fine_rd_trap,
    input  logic              el3_fine_en,
    input  logic              hyp_pm_trap,
    input  logic              mon_pm_trap,
    input  logic              sdd_undef_prio,
    input  logic              sdd_undef,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic [2:0]        rsp_kind,
    output logic [5:0]        rsp_ec,
    output logic [DATA_W-1:0] rsp_data
);
    localparam int HALF   = DATA_W / 2;
    localparam int NHALF  = 2;

    sysenc_t           enc;
    trapcfg_t          cfg;
    logic              hit;
    outcome_e          kind_c;
    logic [5:0]        ec_c;
    logic [DATA_W-1:0] map_vis;
    logic [DATA_W-1:0] data_c;
    outcome_e          kind_q;

    assign enc = '{op0: req_op0, op1: req_op1, crn: req_crn, crm: req_crm, op2: req_op2};

    assign cfg = '{has_pmu:     has_pmu,
                   has_uext:    has_user_ext,
                   has_fgt:     has_fine_trap,
                   has_el3:     has_el3,
                   el2_en:      el2_enabled,
                   in_host:     el0_host,
                   route_gen:   el2_route_gen,
                   usr_en:      usr_access_en,
                   usr_ext_en:  usr_ext_en,
                   usr_id_trap: usr_id_trap,
                   fgt_rd_trap: fine_rd_trap,
                   el3_fgt_en:  el3_fine_en,
                   hyp_pm_trap: hyp_pm_trap,
                   mon_pm_trap: mon_pm_trap,
                   sdd_prio:    sdd_undef_prio,
                   sdd_undef:   sdd_undef};

    pmu_enc_match #(.MATCH(EVID_HI_ENC)) u_match (
        .enc (enc),
        .hit (hit)
    );

    pmu_trap_chain u_chain (
        .lvl  (xlevel_e'(req_el)),
        .hit  (hit),
        .cfg  (cfg),
        .kind (kind_c),
        .ec   (ec_c)
    );

    // Upper half of the bitmap is visible only with the high-window feature
    for (genvar h = 0; h < NHALF; h++) begin : g_half
        if (h == 0) begin : g_lo
            assign map_vis[h*HALF +: HALF] = EVT_MAP[h*HALF +: HALF];
        end else begin : g_hi
            assign map_vis[h*HALF +: HALF] = has_hi_events ? EVT_MAP[h*HALF +: HALF] : '0;
        end
    end

    assign data_c = (kind_c == OUT_READ) ? map_vis : '0;

    pmu_rsp_stage #(.DATA_W(DATA_W)) u_stage (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (req_valid),
        .in_ready  (req_ready),
        .in_kind   (kind_c),
        .in_ec     (ec_c),
        .in_data   (data_c),
        .out_valid (rsp_valid),
        .out_ready (rsp_ready),
        .out_kind  (kind_q),
        .out_ec    (rsp_ec),
        .out_data  (rsp_data)
    );

    assign rsp_kind = kind_q;

    // R2: absent base feature makes a claimed access UNDEFINED
    a_r2_no_pmu_undef: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && hit && !has_pmu) |=> (rsp_kind == 3'd1));

    // R8: EL3 always reads when the feature is present
    a_r8_el3_reads: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && hit && has_pmu && (req_el == 2'd3))
        |=> (rsp_kind == 3'd0));

    // R1: foreign encoding is never claimed
    a_r1_foreign: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && !hit) |=> (rsp_kind == 3'd5));
endmodule

// File: tb/pmu_evid_rd_arb_tb.sv
`timescale 1ns/1ps
module pmu_evid_rd_arb_tb;
    localparam logic [63:0] MAP = 64'hA5C3_0F1E_0001_8421;
    localparam int NCYC = 6000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_valid = 1'b0, rsp_ready = 1'b0;
    logic req_ready, rsp_valid;
    logic [1:0] req_el = '0, req_op0 = '0;
    logic [2:0] req_op1 = '0, req_op2 = '0;
    logic [3:0] req_crn = '0, req_crm = '0;
    logic has_pmu = 0, has_hi_events = 0, has_user_ext = 0, has_fine_trap = 0;
    logic has_el3 = 0, el2_enabled = 0, el0_host = 0, el2_route_gen = 0;
    logic usr_access_en = 0, usr_ext_en = 0, usr_id_trap = 0, fine_rd_trap = 0;
    logic el3_fine_en = 0, hyp_pm_trap = 0, mon_pm_trap = 0;
    logic sdd_undef_prio = 0, sdd_undef = 0;
    logic [2:0]  rsp_kind;
    logic [5:0]  rsp_ec;
    logic [63:0] rsp_data;

    int total = 0;
    int fails = 0;
    bit done  = 0;
    int        q_kind[$];
    logic [63:0] q_data[$];
    string     q_tag[$];

    always #2 clk = ~clk;

    pmu_evid_rd_arb #(.DATA_W(64), .EVT_MAP(MAP)) u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_el(req_el), .req_op0(req_op0), .req_op1(req_op1), .req_crn(req_crn),
        .req_crm(req_crm), .req_op2(req_op2), .has_pmu(has_pmu),
        .has_hi_events(has_hi_events), .has_user_ext(has_user_ext),
        .has_fine_trap(has_fine_trap), .has_el3(has_el3), .el2_enabled(el2_enabled),
        .el0_host(el0_host), .el2_route_gen(el2_route_gen),
        .usr_access_en(usr_access_en), .usr_ext_en(usr_ext_en),
        .usr_id_trap(usr_id_trap), .fine_rd_trap(fine_rd_trap),
        .el3_fine_en(el3_fine_en), .hyp_pm_trap(hyp_pm_trap),
        .mon_pm_trap(mon_pm_trap), .sdd_undef_prio(sdd_undef_prio),
        .sdd_undef(sdd_undef), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
        .rsp_kind(rsp_kind), .rsp_ec(rsp_ec), .rsp_data(rsp_data)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic bit rare();
        return ($urandom % 5) == 0;
    endfunction

    function automatic bit often();
        return ($urandom % 5) != 0;
    endfunction

    task automatic pick_request();
        int sel;
        req_el  = 2'($urandom % 4);
        req_op0 = 2'b11; req_op1 = 3'b011; req_crn = 4'b1001;
        req_crm = 4'b1100; req_op2 = 3'b111;
        sel = $urandom % 12;
        case (sel)
            0: req_op0 = 2'b10;
            1: req_op1 = 3'b000;
            2: req_crn = 4'b1110;
            3: req_crm = 4'b1101;
            4: req_op2 = 3'b110;
            default: ;
        endcase
        has_pmu        = ($urandom % 12) != 0;
        has_hi_events  = $urandom % 2;
        has_user_ext   = $urandom % 2;
        has_fine_trap  = often();
        has_el3        = $urandom % 2;
        el2_enabled    = often();
        el0_host       = $urandom % 2;
        el2_route_gen  = $urandom % 2;
        usr_access_en  = often();
        usr_ext_en     = $urandom % 2;
        usr_id_trap    = rare();
        fine_rd_trap   = rare();
        el3_fine_en    = $urandom % 2;
        hyp_pm_trap    = rare();
        mon_pm_trap    = rare();
        sdd_undef_prio = $urandom % 2;
        sdd_undef      = $urandom % 2;
    endtask

    // Behavioural expectation from the requirements; kind codes per R13
    task automatic model(output int k, output string tag);
        bit claimed;
        bit to_el2;
        claimed = (req_op0 == 2'd3) && (req_op1 == 3'd3) && (req_crn == 4'd9)
                  && (req_crm == 4'd12) && (req_op2 == 3'd7);
        to_el2  = el2_enabled && el2_route_gen;
        k = 0; tag = "R10";
        if (!claimed)      begin k = 5; tag = "R1"; return; end
        if (!has_pmu)      begin k = 1; tag = "R2"; return; end
        if (req_el == 2'd3) begin k = 0; tag = "R8"; return; end
        if (has_el3 && sdd_undef_prio && mon_pm_trap) begin k = 1; tag = "R3"; return; end
        if (req_el == 2'd0) begin
            if (!usr_access_en && !(has_user_ext && usr_ext_en)) begin
                k = to_el2 ? 3 : 2; tag = "R4"; return;
            end
            if (has_user_ext && usr_id_trap) begin
                k = to_el2 ? 3 : 2; tag = "R5"; return;
            end
        end
        if (req_el != 2'd2) begin
            if (el2_enabled && has_fine_trap && fine_rd_trap
                && (!has_el3 || el3_fine_en) && !(req_el == 2'd0 && el0_host)) begin
                k = 3; tag = "R6"; return;
            end
            if (el2_enabled && hyp_pm_trap) begin k = 3; tag = "R7"; return; end
        end
        if (has_el3 && mon_pm_trap) begin
            k = sdd_undef ? 1 : 4; tag = "R8"; return;
        end
    endtask

    initial begin
        #(4ns * 150000);
        if (!done) begin
            fails++; total++;
            $display("FAIL watchdog: run did not complete");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        int k;
        string tag;
        logic [63:0] exp_data;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(rsp_valid == 1'b0, "R12", "rsp_valid in reset", 64'(rsp_valid), 64'd0);
        rst = 1'b0;
        @(negedge clk);
        chk(rsp_valid == 1'b0, "R12", "rsp_valid after reset", 64'(rsp_valid), 64'd0);
        chk(req_ready == 1'b1, "R12", "req_ready after reset", 64'(req_ready), 64'd1);

        for (int cyc = 0; cyc < NCYC; cyc++) begin
            // compare outputs with the model's pending response
            chk(rsp_valid == (q_kind.size() != 0), "R11", "rsp_valid timing",
                64'(rsp_valid), 64'(q_kind.size() != 0));
            if (rsp_valid && q_kind.size() != 0) begin
                chk(rsp_kind == 3'(q_kind[0]), q_tag[0], "rsp_kind",
                    64'(rsp_kind), 64'(q_kind[0]));
                chk(rsp_ec == ((q_kind[0] >= 2 && q_kind[0] <= 4) ? 6'h18 : 6'h00),
                    "R9", "rsp_ec", 64'(rsp_ec),
                    (q_kind[0] >= 2 && q_kind[0] <= 4) ? 64'h18 : 64'h0);
                chk(rsp_data == q_data[0], "R10", "rsp_data", rsp_data, q_data[0]);
            end
            // new stimulus
            rsp_ready = ($urandom % 3) != 0;
            req_valid = ($urandom % 4) != 0;
            pick_request();
            #1;
            chk(req_ready == (!rsp_valid || rsp_ready), "R11", "req_ready",
                64'(req_ready), 64'(!rsp_valid || rsp_ready));
            if (rsp_valid && rsp_ready && q_kind.size() != 0) begin
                void'(q_kind.pop_front());
                void'(q_data.pop_front());
                void'(q_tag.pop_front());
            end
            if (req_valid && (!rsp_valid || rsp_ready)) begin
                model(k, tag);
                exp_data = '0;
                if (k == 0)
                    exp_data = {has_hi_events ? MAP[63:32] : 32'h0, MAP[31:0]};
                q_kind.push_back(k);
                q_data.push_back(exp_data);
                q_tag.push_back(tag);
            end
            @(negedge clk);
        end
        done = 1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule